// File: doc/BRIEF.md
# Power-Fail Sequencing Controller

This block decides how a system controller behaves across a supply failure. It follows the chip through seven states: full-speed operation, a power-fail state for software cleanup, a single refresh before freezing, a frozen state that keeps DRAM refreshed, a frozen state with no refresh, a restore state while the CPU is held in reset, and a slow power-save mode. From these states it drives the fast-oscillator enable, the core-clock freeze, the divide-by-16 select, a refresh request pulse and a flag that marks the forced default refresh rate.

The power-fail input arrives asynchronously and passes through a two-stage synchronizer before it is used. Software loads an elapsed-time down-counter before the CPU is reset. The counter steps on an always-on slow tick while the chip is frozen. When it reaches zero in the refreshing freeze, the block stops refresh and falls back to the counter-only freeze. The counter value stays readable after restore, so software can learn how long the outage lasted.

Top module: `pwr_seq_ctrl`

## Requirements
- R1: Reset (synchronous, active high) enters the restore state. The 3-bit `state_code` encodings are: 1 run, 2 power fail, 3 single refresh, 4 freeze with refresh, 5 freeze without refresh, 6 restore, 7 slow. Reset values are osc_en=1, core_freeze=0, clk_slow=0, refresh_req=0, etc_value=0.
- R2: With power fail asserted in state 1 or 7, the state becomes 2. A change of `pfail_async` is acted on at the third rising edge after it.
- R3: State 1 moves to 7 only on `sw_req_save`, and state 7 moves to 1 only on `sw_req_normal`. The other request has no effect in each state. `clk_slow` is high exactly in state 7.
- R4: In state 2, `cpu_rst` high leads to state 3 when `refresh_en` is 1 and to state 5 when it is 0.
- R5: State 3 lasts one cycle and is followed by state 4. `refresh_req` is high for that first cycle of state 4.
- R6: `osc_en` is low and `core_freeze` is high exactly in states 4 and 5.
- R7: In state 4, `refresh_req` pulses once every REF_PERIOD cycles, the first pulse REF_PERIOD cycles after entry.
- R8: `etc_load` sets the counter to `etc_load_val`. A `tick_slow` in state 4 or 5 decrements it, and it saturates at 0. In all other states it holds, and its value is visible on `etc_value`.
- R9: In state 4, a counter value of 0 moves to state 5. No refresh pulse occurs in state 5.
- R10: In state 4 or 5, synchronized power fail low moves to state 6. This takes priority over counter expiry in the same cycle.
- R11: In state 6 with `refresh_en` high, `refresh_req` pulses every DFLT_PERIOD cycles and `refresh_dflt` is high. With `refresh_en` low there are no pulses and `refresh_dflt` is low.
- R12: In state 6, `cpu_rst` low leads to state 7. In state 1 or 7 without power fail, `cpu_rst` high leads to state 6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous active-high reset |
| pfail_async | input | 1 | Asynchronous power-fail indication, high = failing |
| cpu_rst | input | 1 | CPU reset line, high = reset asserted |
| refresh_en | input | 1 | DRAM refresh enabled |
| sw_req_save | input | 1 | Software request: run to slow mode |
| sw_req_normal | input | 1 | Software request: slow to run mode |
| tick_slow | input | 1 | Always-on slow clock-enable for the elapsed-time counter |
| etc_load | input | 1 | Load the elapsed-time counter |
| etc_load_val | input | ETC_W | Elapsed-time counter start value |
| osc_en | output | 1 | Fast oscillator enable |
| core_freeze | output | 1 | Core clock frozen |
| clk_slow | output | 1 | Select divide-by-16 CPU clock |
| refresh_req | output | 1 | One-cycle refresh request |
| refresh_dflt | output | 1 | Refresh runs at forced default rate |
| etc_value | output | ETC_W | Current elapsed-time count |
| state_code | output | 3 | Current state encoding |

## Verification
The one collision in this block comes from the frozen-with-refresh state. There, the elapsed-time counter can reach zero in the same cycle as the synchronized power-fail input drops. The bench provokes this by clearing power fail one cycle before a slow tick, which brings the counter from 1 to 0. Because the synchronizer adds two stages of latency, both conditions then reach the state register at the same edge. A correct design enters restore (6) and does not pass through counter-only freeze (5). Counter load and tick can also coincide, and the load is then taken.

// File: rtl/pwr_seq_pkg.sv
package pwr_seq_pkg;
  typedef enum logic [2:0] {
    ST_RUN      = 3'd1,
    ST_FAIL     = 3'd2,
    ST_REFONE   = 3'd3,
    ST_HOLD_REF = 3'd4,
    ST_HOLD     = 3'd5,
    ST_WAKE     = 3'd6,
    ST_SLOW     = 3'd7
  } pstate_e;
endpackage

// File: rtl/pwr_sync.sv
module pwr_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sh;

  always_ff @(posedge clk) begin
    if (rst) sh <= '0;
    else     sh <= {sh[STAGES-2:0], d};
  end

  assign q = sh[STAGES-1];
endmodule

// File: rtl/pwr_etc.sv
module pwr_etc #(
  parameter int ETC_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [ETC_W-1:0] load_val,
  input  logic             tick,
  input  logic             run,
  output logic [ETC_W-1:0] value,
  output logic             zero
);
  always_ff @(posedge clk) begin
    if (rst)                            value <= '0;
    else if (load)                      value <= load_val;
    else if (run && tick && value != 0) value <= value - 1'b1;
  end

  assign zero = (value == '0);
endmodule

// File: rtl/pwr_ref_gen.sv
module pwr_ref_gen #(
  parameter int REF_PERIOD  = 16,
  parameter int DFLT_PERIOD = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  input  logic use_dflt,
  output logic tick
);
  localparam int MAXP = (REF_PERIOD > DFLT_PERIOD) ? REF_PERIOD : DFLT_PERIOD;
  localparam int CW   = (MAXP > 2) ? $clog2(MAXP) : 1;
  localparam logic [CW-1:0] REF_LAST  = CW'(REF_PERIOD - 1);
  localparam logic [CW-1:0] DFLT_LAST = CW'(DFLT_PERIOD - 1);

  logic [CW-1:0] cnt;
  logic [CW-1:0] last;

  assign last = use_dflt ? DFLT_LAST : REF_LAST;
  assign tick = run && (cnt >= last);

  always_ff @(posedge clk) begin
    if (rst || !run)   cnt <= '0;
    else if (cnt >= last) cnt <= '0;
    else               cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/pwr_fsm.sv
module pwr_fsm
  import pwr_seq_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    pfail,
  input  logic    cpu_rst,
  input  logic    refresh_en,
  input  logic    sw_req_save,
  input  logic    sw_req_normal,
  input  logic    etc_zero,
  input  logic    ref_tick,
  output pstate_e state,
  output logic    ref_run,
  output logic    ref_dflt_mode,
  output logic    etc_run,
  output logic    osc_en,
  output logic    core_freeze,
  output logic    clk_slow,
  output logic    refresh_req,
  output logic    refresh_dflt
);
  pstate_e nxt;

  always_comb begin
    nxt = state;
    unique case (state)
      ST_RUN: begin
        if (pfail)            nxt = ST_FAIL;
        else if (cpu_rst)     nxt = ST_WAKE;
        else if (sw_req_save) nxt = ST_SLOW;
      end
      ST_SLOW: begin
        if (pfail)              nxt = ST_FAIL;
        else if (cpu_rst)       nxt = ST_WAKE;
        else if (sw_req_normal) nxt = ST_RUN;
      end
      ST_FAIL:     if (cpu_rst) nxt = refresh_en ? ST_REFONE : ST_HOLD;
      ST_REFONE:   nxt = ST_HOLD_REF;
      ST_HOLD_REF: begin
        if (!pfail)        nxt = ST_WAKE;
        else if (etc_zero) nxt = ST_HOLD;
      end
      ST_HOLD:     if (!pfail) nxt = ST_WAKE;
      ST_WAKE:     if (!cpu_rst) nxt = ST_SLOW;
      default:     nxt = ST_WAKE;
    endcase
  end

  assign ref_run       = (state == ST_HOLD_REF) || (state == ST_WAKE && refresh_en);
  assign ref_dflt_mode = (state == ST_WAKE);
  assign etc_run       = (state == ST_HOLD_REF) || (state == ST_HOLD);

  always_ff @(posedge clk) begin
    if (rst) begin
      state        <= ST_WAKE;
      osc_en       <= 1'b1;
      core_freeze  <= 1'b0;
      clk_slow     <= 1'b0;
      refresh_req  <= 1'b0;
      refresh_dflt <= 1'b0;
    end else begin
      state        <= nxt;
      osc_en       <= !(nxt == ST_HOLD_REF || nxt == ST_HOLD);
      core_freeze  <= (nxt == ST_HOLD_REF || nxt == ST_HOLD);
      clk_slow     <= (nxt == ST_SLOW);
      refresh_req  <= (state == ST_REFONE)
                   || (ref_tick && state == ST_HOLD_REF && nxt == ST_HOLD_REF)
                   || (ref_tick && state == ST_WAKE);
      refresh_dflt <= (nxt == ST_WAKE) && refresh_en;
    end
  end
endmodule

// File: rtl/pwr_seq_ctrl.sv
module pwr_seq_ctrl
  import pwr_seq_pkg::*;
#(
  parameter int ETC_W       = 16,
  parameter int SYNC_STAGES = 2,
  parameter int REF_PERIOD  = 16,
  parameter int DFLT_PERIOD = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             pfail_async,
  input  logic             cpu_rst,
  input  logic             refresh_en,
  input  logic             sw_req_save,
  input  logic             sw_req_normal,
  input  logic             tick_slow,
  input  logic             etc_load,
  input  logic [ETC_W-1:0] etc_load_val,
  output logic             osc_en,
  output logic             core_freeze,
  output logic             clk_slow,
  output logic             refresh_req,
  output logic             refresh_dflt,
  output logic [ETC_W-1:0] etc_value,
  output logic [2:0]       state_code
);
  logic    pfail_s, etc_zero, ref_tick, ref_run, ref_dflt_mode, etc_run;
  pstate_e state;

  pwr_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d(pfail_async), .q(pfail_s)
  );

  pwr_etc #(.ETC_W(ETC_W)) u_etc (
    .clk(clk), .rst(rst), .load(etc_load), .load_val(etc_load_val),
    .tick(tick_slow), .run(etc_run), .value(etc_value), .zero(etc_zero)
  );

  pwr_ref_gen #(.REF_PERIOD(REF_PERIOD), .DFLT_PERIOD(DFLT_PERIOD)) u_ref (
    .clk(clk), .rst(rst), .run(ref_run), .use_dflt(ref_dflt_mode), .tick(ref_tick)
  );

  pwr_fsm u_fsm (
    .clk(clk), .rst(rst), .pfail(pfail_s), .cpu_rst(cpu_rst),
    .refresh_en(refresh_en), .sw_req_save(sw_req_save),
    .sw_req_normal(sw_req_normal), .etc_zero(etc_zero), .ref_tick(ref_tick),
    .state(state), .ref_run(ref_run), .ref_dflt_mode(ref_dflt_mode),
    .etc_run(etc_run), .osc_en(osc_en), .core_freeze(core_freeze),
    .clk_slow(clk_slow), .refresh_req(refresh_req), .refresh_dflt(refresh_dflt)
  );

  assign state_code = state;
endmodule

// File: rtl/pwr_seq_chk.sv
module pwr_seq_chk #(
  parameter int ETC_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic [2:0]       state_code,
  input logic             osc_en,
  input logic             core_freeze,
  input logic             clk_slow,
  input logic             refresh_req,
  input logic             etc_load,
  input logic [ETC_W-1:0] etc_value
);
  assert_legal_code_R1: assert property (@(posedge clk) disable iff (rst)
    state_code != 3'd0);

  assert_slow_only_s7_R3: assert property (@(posedge clk) disable iff (rst)
    clk_slow == (state_code == 3'd7));

  assert_single_refresh_R5: assert property (@(posedge clk) disable iff (rst)
    (state_code == 3'd3) |=> (state_code == 3'd4 && refresh_req));

  assert_freeze_states_R6: assert property (@(posedge clk) disable iff (rst)
    (core_freeze == (state_code == 3'd4 || state_code == 3'd5)) && (osc_en == !core_freeze));

  assert_etc_saturate_R8: assert property (@(posedge clk) disable iff (rst)
    (etc_value == '0 && !etc_load) |=> (etc_value == '0));

  assert_no_refresh_s5_R9: assert property (@(posedge clk) disable iff (rst)
    (state_code == 3'd5) |-> !refresh_req);

  assert_s5_exit_R10: assert property (@(posedge clk) disable iff (rst)
    (state_code == 3'd5) |=> (state_code == 3'd5 || state_code == 3'd6));

  assert_run_exit_R12: assert property (@(posedge clk) disable iff (rst)
    (state_code == 3'd1) |=> (state_code inside {3'd1, 3'd2, 3'd6, 3'd7}));
endmodule

bind pwr_seq_ctrl pwr_seq_chk #(.ETC_W(ETC_W)) u_chk (
  .clk(clk), .rst(rst), .state_code(state_code), .osc_en(osc_en),
  .core_freeze(core_freeze), .clk_slow(clk_slow), .refresh_req(refresh_req),
  .etc_load(etc_load), .etc_value(etc_value)
);

// File: tb/tb_pwr_seq_ctrl.sv
`timescale 1ns/1ps
module tb_pwr_seq_ctrl;
  localparam int ETC_W = 16;
  localparam int REFP  = 16;
  localparam int DFLTP = 8;

  logic clk = 1'b0;
  logic rst, pfail_async, cpu_rst, refresh_en, sw_req_save, sw_req_normal;
  logic tick_slow, etc_load;
  logic [ETC_W-1:0] etc_load_val;
  logic osc_en, core_freeze, clk_slow, refresh_req, refresh_dflt;
  logic [ETC_W-1:0] etc_value;
  logic [2:0] state_code;

  int errors = 0;
  int checks = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  pwr_seq_ctrl #(.ETC_W(ETC_W), .SYNC_STAGES(2), .REF_PERIOD(REFP), .DFLT_PERIOD(DFLTP)) dut (
    .clk(clk), .rst(rst), .pfail_async(pfail_async), .cpu_rst(cpu_rst),
    .refresh_en(refresh_en), .sw_req_save(sw_req_save), .sw_req_normal(sw_req_normal),
    .tick_slow(tick_slow), .etc_load(etc_load), .etc_load_val(etc_load_val),
    .osc_en(osc_en), .core_freeze(core_freeze), .clk_slow(clk_slow),
    .refresh_req(refresh_req), .refresh_dflt(refresh_dflt),
    .etc_value(etc_value), .state_code(state_code)
  );

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic count_refresh(input int n, output int cnt);
    cnt = 0;
    for (int i = 0; i < n; i++) begin
      step(1);
      if (refresh_req) cnt++;
    end
  endtask

  task automatic slow_tick();
    tick_slow = 1'b1; step(1);
    tick_slow = 1'b0; step(1);
  endtask

  task automatic load_etc(input int v);
    etc_load = 1'b1; etc_load_val = ETC_W'(v); step(1);
    etc_load = 1'b0;
  endtask

  task automatic t_reset_and_restore();
    int c;
    rst = 1'b1; cpu_rst = 1'b1; pfail_async = 1'b0; refresh_en = 1'b0;
    sw_req_save = 1'b0; sw_req_normal = 1'b0; tick_slow = 1'b0;
    etc_load = 1'b0; etc_load_val = '0;
    step(3);
    chk("R1 state", state_code, 6);
    chk("R1 osc_en", osc_en, 1);
    chk("R1 freeze", core_freeze, 0);
    chk("R1 slow", clk_slow, 0);
    chk("R1 refresh", refresh_req, 0);
    chk("R1 etc", etc_value, 0);
    rst = 1'b0; step(4);
    chk("R12 hold in 6 while cpu_rst", state_code, 6);
    count_refresh(16, c);
    chk("R11 no refresh when disabled", c, 0);
    chk("R11 dflt flag low", refresh_dflt, 0);
    refresh_en = 1'b1;
    count_refresh(24, c);
    chk("R11 default-rate pulses", c, 3);
    chk("R11 dflt flag high", refresh_dflt, 1);
    cpu_rst = 1'b0; refresh_en = 1'b0; step(1);
    chk("R12 6 to 7", state_code, 7);
    chk("R3 slow select", clk_slow, 1);
  endtask

  task automatic t_mode_requests();
    step(5);
    chk("R3 stay 7 without request", state_code, 7);
    sw_req_save = 1'b1; step(1); sw_req_save = 1'b0;
    chk("R3 save ignored in 7", state_code, 7);
    sw_req_normal = 1'b1; step(1); sw_req_normal = 1'b0;
    chk("R3 7 to 1", state_code, 1);
    chk("R3 full speed", clk_slow, 0);
    sw_req_normal = 1'b1; step(1); sw_req_normal = 1'b0;
    chk("R3 normal ignored in 1", state_code, 1);
    sw_req_save = 1'b1; step(1); sw_req_save = 1'b0;
    chk("R3 1 to 7", state_code, 7);
    sw_req_normal = 1'b1; step(1); sw_req_normal = 1'b0;
    cpu_rst = 1'b1; step(1);
    chk("R12 1 to 6 on cpu reset", state_code, 6);
    cpu_rst = 1'b0; step(1);
    chk("R12 back to 7", state_code, 7);
    sw_req_normal = 1'b1; step(1); sw_req_normal = 1'b0;
    chk("R3 back to 1", state_code, 1);
  endtask

  task automatic t_fail_with_refresh();
    int c;
    refresh_en = 1'b1;
    pfail_async = 1'b1; step(2);
    chk("R2 not yet synchronized", state_code, 1);
    step(1);
    chk("R2 1 to 2", state_code, 2);
    load_etc(3);
    cpu_rst = 1'b1; step(1);
    chk("R4 2 to 3 with refresh", state_code, 3);
    step(1);
    chk("R5 3 to 4", state_code, 4);
    chk("R5 one refresh pulse", refresh_req, 1);
    chk("R6 osc off", osc_en, 0);
    chk("R6 frozen", core_freeze, 1);
    count_refresh(3 * REFP, c);
    chk("R7 periodic refresh in 4", c, 3);
    chk("R8 etc holds without tick", etc_value, 3);
    slow_tick(); slow_tick(); slow_tick();
    chk("R9 4 to 5 on expiry", state_code, 5);
    chk("R8 etc reached zero", etc_value, 0);
    slow_tick(); slow_tick();
    chk("R8 etc saturates", etc_value, 0);
    count_refresh(40, c);
    chk("R9 no refresh in 5", c, 0);
    pfail_async = 1'b0; step(3);
    chk("R10 5 to 6", state_code, 6);
    chk("R6 osc back on", osc_en, 1);
    cpu_rst = 1'b0; step(1);
    chk("R12 restore to 7", state_code, 7);
  endtask

  task automatic t_fail_no_refresh();
    int c;
    refresh_en = 1'b0;
    pfail_async = 1'b1; step(3);
    chk("R2 7 to 2", state_code, 2);
    load_etc(5);
    cpu_rst = 1'b1; step(1);
    chk("R4 2 to 5 without refresh", state_code, 5);
    chk("R6 frozen in 5", core_freeze, 1);
    slow_tick(); slow_tick();
    chk("R8 etc counts in 5", etc_value, 3);
    pfail_async = 1'b0; step(3);
    chk("R10 5 to 6", state_code, 6);
    slow_tick();
    chk("R8 etc holds in 6", etc_value, 3);
    count_refresh(20, c);
    chk("R11 no refresh in 6 when disabled", c, 0);
    cpu_rst = 1'b0; step(1);
    chk("R12 to 7", state_code, 7);
  endtask

  task automatic t_collision();
    refresh_en = 1'b1;
    pfail_async = 1'b1; step(3);
    load_etc(1);
    cpu_rst = 1'b1; step(2);
    chk("R5 in 4 before collision", state_code, 4);
    pfail_async = 1'b0; step(1);
    tick_slow = 1'b1; step(1); tick_slow = 1'b0;
    step(1);
    chk("R10 restore wins over expiry", state_code, 6);
    chk("R8 etc zero after collision", etc_value, 0);
    tick_slow = 1'b1; etc_load = 1'b1; etc_load_val = 16'd9; step(1);
    tick_slow = 1'b0; etc_load = 1'b0;
    chk("R8 load wins over tick", etc_value, 9);
    cpu_rst = 1'b0; refresh_en = 1'b0; step(1);
    chk("R12 final 7", state_code, 7);
  endtask

  initial begin
    t_reset_and_restore();
    t_mode_requests();
    t_fail_with_refresh();
    t_fail_no_refresh();
    t_collision();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule